// File: doc/BRIEF.md
# MicroWire Serial Master

A memory-mapped master for a three-wire MicroWire bus with four chip-select outputs. Software reaches eight 16-bit words through a 3-bit word index. Index 0 is the transmit register on write and the receive register on read. Index 1 holds the command and status word. Indices 2 to 6 are five setup words. Each chip select has its own 6-bit setting: sampling edge, driving edge, chip-select polarity and serial-clock divider. Two of these settings are packed into each of the first two setup words.

To run a transfer, software first asserts a chip select through the command word. It then loads the transmit register and writes the command word again with the start bit, a write length and a read length. After that it polls the busy and receive-ready flags. The write phase sends the transmit word starting from bit 15. The read phase then shifts the input line into the low end of the receive register. Both phases run under the same chip select.

A separate prescaler supplies the base rate for the serial clock as a single-cycle `tick` pulse. Each half period of the serial clock lasts 1, 2 or 4 ticks.

Top module: `mw_serial_master`

## Requirements
- R1: Register map. A write to index 0 loads the transmit register, and a read of index 0 returns the receive register. Index 1 reads as {ready[15], busy[14], 0[13], chip-select command[12], chip-select index[11:10], write-length field[9:5], read-length field[4:0]}. Indices 2..6 hold setup words 1..5 and read back exactly as written. Index 7 reads 0.
- R2: A command-word write with bit 12 set asserts `cs_out[idx]`, where idx is taken from bits 11:10. A write with bit 12 clear deasserts it. Every other output stays inactive. The asserted level of each output is bit 2 of that select's setting (1 = high). The polarity is applied live.
- R3: A command-word write with bit 13 set starts a transfer only when the clamped lengths sum to more than zero. Busy then reads 1 from the next cycle. A length field above 16 counts as 16.
- R4: The serial clock idles at setup word 4 bit 0. During a transfer it inverts every half period. A half period lasts 1, 2 or 4 `tick` pulses for divider bits 4:3 = 00, 01 or 1x. Each bit takes one full period and starts at the idle level.
- R5: Write bits leave from transmit bit 15 downward. If setting bit 1 is 0, bit k is driven for all of bit slot k. If setting bit 1 is 1, bit k appears at the middle of slot k, and `sdo` is 0 in the first half of slot 0. `sdo` is 0 outside the write phase.
- R6: Each read bit is sampled at the middle of its slot (setting bit 0 = 0) or at its end (bit 0 = 1). The sample shifts into bit 0 of the receive register. The receive register is cleared when a transfer with a nonzero read length starts.
- R7: All write bits come before all read bits. Busy clears at the end of the last bit.
- R8: Ready sets when a transfer with a nonzero read length finishes. A read of index 0 clears it. If both happen in the same cycle, the set wins.
- R9: Any command-word write while busy is ignored. It starts no transfer and changes no chip select.
- R10: Selects 0 and 1 take their settings from setup word 1, and selects 2 and 3 from setup word 2. Even selects use bits 5:0 and odd selects use bits 11:6. The edge and divider bits are captured at start.
- R11: After reset, all registers are 0, every chip select is inactive (high), and `sclk` and `sdo` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaler pulse that paces the serial clock |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears ready on index 0) |
| addr | input | 3 | Register word index |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| cs_out | output | 4 | Chip-select outputs at their configured levels |

## Verification
Two functions can fall in the same cycle. The last read bit can complete, setting ready, in the same cycle that software reads index 0, which clears ready. The bench holds a read strobe on index 0 for an entire read transfer, so the finishing edge always meets a read. It then checks that ready is still 1 afterwards. The bench also writes the command word in the middle of a transfer and checks that neither the chip select nor the running transfer changes. A cycle-level model compares `sclk`, `sdo`, `cs_out` and `rdata` on every clock.

// File: rtl/mw_serial_master.sv
module mw_serial_master #(
  parameter int DW = 16,
  parameter int NCS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          sclk,
  output logic          sdo,
  input  logic          sdi,
  output logic [NCS-1:0] cs_out
);
  localparam int CW = $clog2(DW + 1);
  localparam int BW = CW + 1;

  function automatic logic [CW-1:0] clamp_len(input logic [4:0] v);
    return (v > 5'(DW)) ? CW'(DW) : CW'(v);
  endfunction

  logic [DW-1:0] tx_data, rx_data;
  logic [DW-1:0] sreg [5];
  logic          ready, busy, cs_act, phase;
  logic [1:0]    cs_idx, tcnt, div, mode;
  logic [4:0]    ntx_f, nrx_f;
  logic [CW-1:0] tx_n, rx_n;
  logic [BW-1:0] bit_idx;
  logic [DW:0]   sh;

  wire [CW-1:0] go_tx = clamp_len(wdata[9:5]);
  wire [CW-1:0] go_rx = clamp_len(wdata[4:0]);
  wire          csr_wr = wr_en && addr == 3'd1 && !busy;
  wire          go = csr_wr && wdata[13] && ({1'b0, go_tx} + {1'b0, go_rx} != '0);
  wire [DW-1:0] sel = wdata[11] ? sreg[1] : sreg[0];
  wire [1:0]    lat_mode = wdata[10] ? sel[7:6] : sel[1:0];
  wire [1:0]    lat_div = wdata[10] ? sel[10:9] : sel[4:3];
  wire [1:0]    lim = (div == 2'd0) ? 2'd0 : (div == 2'd1) ? 2'd1 : 2'd3;
  wire [BW-1:0] total = {1'b0, tx_n} + {1'b0, rx_n};
  wire          edge_ev = busy && tick && tcnt == lim;
  wire          mid_ev = edge_ev && !phase;
  wire          end_ev = edge_ev && phase;
  wire          in_tx = bit_idx < {1'b0, tx_n};
  wire          last = end_ev && bit_idx == total - 1'b1;
  wire          drive_ev = in_tx && (mode[1] ? mid_ev : end_ev);
  wire          samp_ev = !in_tx && (mode[0] ? end_ev : mid_ev);
  wire          rd_rx = rd_en && addr == 3'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data <= '0; rx_data <= '0; ready <= 1'b0; busy <= 1'b0;
      cs_act <= 1'b0; cs_idx <= '0; ntx_f <= '0; nrx_f <= '0;
      tx_n <= '0; rx_n <= '0; bit_idx <= '0; phase <= 1'b0; tcnt <= '0;
      div <= '0; mode <= '0; sh <= '0;
      for (int k = 0; k < 5; k++) sreg[k] <= '0;
    end else begin
      if (wr_en && addr == 3'd0) tx_data <= wdata;
      for (int k = 0; k < 5; k++)
        if (wr_en && addr == 3'(k + 2)) sreg[k] <= wdata;
      if (csr_wr) begin
        cs_act <= wdata[12];
        cs_idx <= wdata[11:10];
        ntx_f  <= wdata[9:5];
        nrx_f  <= wdata[4:0];
      end
      if (go) begin
        busy <= 1'b1; phase <= 1'b0; tcnt <= '0; bit_idx <= '0;
        tx_n <= go_tx; rx_n <= go_rx; mode <= lat_mode; div <= lat_div;
        sh <= lat_mode[1] ? {1'b0, tx_data} : {tx_data, 1'b0};
        if (go_rx != '0) rx_data <= '0;
      end else if (busy && tick) begin
        if (edge_ev) begin
          phase <= ~phase;
          tcnt  <= '0;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
        if (end_ev) begin
          if (last) busy <= 1'b0;
          else bit_idx <= bit_idx + 1'b1;
        end
        if (drive_ev) sh <= {sh[DW-1:0], 1'b0};
        if (samp_ev) rx_data <= {rx_data[DW-2:0], sdi};
      end
      if (last && rx_n != '0) ready <= 1'b1;
      else if (rd_rx) ready <= 1'b0;
    end
  end

  assign sclk = sreg[3][0] ^ (busy & phase);
  assign sdo  = busy && in_tx && sh[DW];

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    wire pol = sreg[i / 2][6 * (i % 2) + 2];
    assign cs_out[i] = pol ? (cs_act && cs_idx == 2'(i)) : !(cs_act && cs_idx == 2'(i));
  end

  always_comb begin
    case (addr)
      3'd0: rdata = rx_data;
      3'd1: rdata = {ready, busy, 1'b0, cs_act, cs_idx, ntx_f, nrx_f};
      3'd2, 3'd3, 3'd4, 3'd5, 3'd6: rdata = sreg[addr - 3'd2];
      default: rdata = '0;
    endcase
  end

  a_r3_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);
  a_r9_csr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && addr == 3'd1) |=> $stable({cs_act, cs_idx}));
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (last && rx_n != '0) |=> ready);
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !(last && rx_n != '0)) |=> !ready);
  a_r4_sclk_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !edge_ev && !wr_en) |=> $stable(sclk));
  a_r7_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bit_idx < total);
endmodule

// File: tb/mw_serial_master_bench.sv
`timescale 1ns/1ps
module mw_serial_master_bench;
  logic clk = 0, rst_n = 0, tick = 1, wr_en = 0, rd_en = 0, sdi = 0;
  logic [2:0] addr = 0;
  logic [15:0] wdata = 0;
  wire [15:0] rdata;
  wire sclk, sdo;
  wire [3:0] cs_out;

  mw_serial_master u_mw_serial_master (.clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .sclk(sclk), .sdo(sdo), .sdi(sdi), .cs_out(cs_out));

  always #5 clk = ~clk;

  int vecs = 0, fails = 0, cyc = 0, tick_mode = 0;
  bit started = 0, finished = 0;
  logic [7:0] lfsr = 8'hA7;

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s got %0h exp %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference
  int m_busy, m_ph, m_tc, m_bit, m_ntx, m_nrx, m_cfg, m_ready, m_csact, m_csidx;
  int m_ntxf, m_nrxf, m_tx, m_txl, m_rx;
  int m_setup [5];

  function automatic int fld(int c);
    return (m_setup[c / 2] >> (6 * (c % 2))) & 63;
  endfunction
  function automatic int half_ticks(int cfg);
    int d = (cfg >> 3) & 3;
    return d == 0 ? 1 : d == 1 ? 2 : 4;
  endfunction
  function automatic int clampv(int v);
    return v > 16 ? 16 : v;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_ph = 0; m_tc = 0; m_bit = 0; m_ntx = 0; m_nrx = 0; m_cfg = 0;
      m_ready = 0; m_csact = 0; m_csidx = 0; m_ntxf = 0; m_nrxf = 0;
      m_tx = 0; m_txl = 0; m_rx = 0;
      foreach (m_setup[k]) m_setup[k] = 0;
    end else begin
      int ob, done, intx, nt, nr;
      ob = m_busy; done = 0;
      intx = m_bit < m_ntx;
      if (m_busy && tick) begin
        if (m_tc == half_ticks(m_cfg) - 1) begin
          if (!intx && ((m_cfg & 1) != 0) == (m_ph == 1))
            m_rx = ((m_rx << 1) | sdi) & 16'hFFFF;
          if (m_ph == 1) begin
            if (m_bit == m_ntx + m_nrx - 1) done = 1;
            else m_bit++;
          end
          m_ph ^= 1; m_tc = 0;
        end else m_tc++;
      end
      if (done) m_busy = 0;
      if (done && m_nrx > 0) m_ready = 1;
      else if (rd_en && addr == 0) m_ready = 0;
      if (wr_en) begin
        if (addr == 0) m_tx = wdata;
        else if (addr >= 2 && addr <= 6) m_setup[addr - 2] = wdata;
        else if (addr == 1 && !ob) begin
          m_csact = wdata[12]; m_csidx = wdata[11:10];
          m_ntxf = wdata[9:5]; m_nrxf = wdata[4:0];
          nt = clampv(m_ntxf); nr = clampv(m_nrxf);
          if (wdata[13] && nt + nr > 0) begin
            m_busy = 1; m_ph = 0; m_tc = 0; m_bit = 0; m_ntx = nt; m_nrx = nr;
            m_cfg = fld(m_csidx); m_txl = m_tx;
            if (nr > 0) m_rx = 0;
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    sdi = lfsr[0];
    tick = (tick_mode == 0) ? 1'b1 : (cyc % 3 == 0);
  end

  function automatic int exp_sdo();
    if (!m_busy || m_bit >= m_ntx) return 0;
    if ((m_cfg & 2) != 0 && m_ph == 0)
      return m_bit == 0 ? 0 : (m_txl >> (16 - m_bit)) & 1;
    return (m_txl >> (15 - m_bit)) & 1;
  endfunction
  function automatic int exp_rdata(int a);
    case (a)
      0: return m_rx;
      1: return (m_ready << 15) | (m_busy << 14) | (m_csact << 12) | (m_csidx << 10)
                | (m_ntxf << 5) | m_nrxf;
      2, 3, 4, 5, 6: return m_setup[a - 2];
      default: return 0;
    endcase
  endfunction
  function automatic int exp_cs();
    int v = 0;
    for (int i = 0; i < 4; i++) begin
      int on = m_csact && m_csidx == i;
      int pol = (fld(i) >> 2) & 1;
      v |= (pol ? on : !on) << i;
    end
    return v;
  endfunction

  always @(negedge clk) if (started && !finished) begin
    chk("R4 sclk", sclk, (m_setup[3] & 1) ^ (m_busy & m_ph));
    chk("R5 sdo", sdo, exp_sdo());
    chk("R2 cs_out", cs_out, exp_cs());
    chk(addr == 0 ? "R6 rdata" : addr == 1 ? "R8 rdata" : "R1 rdata", rdata, exp_rdata(addr));
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #2; addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #2; wr_en = 0;
  endtask
  task automatic peek(input logic [2:0] a, input logic r, output logic [15:0] v);
    @(posedge clk); #2; addr = a; rd_en = r;
    @(negedge clk); v = rdata;
    @(posedge clk); #2; rd_en = 0;
  endtask
  task automatic wait_idle();
    @(posedge clk); #1;
    while (m_busy) begin @(posedge clk); #1; end
  endtask
  function automatic logic [15:0] cmd(int st, int on, int idx, int nt, int nr);
    return 16'((st << 13) | (on << 12) | (idx << 10) | (nt << 5) | nr);
  endfunction

  task automatic summary();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL R7 watchdog expired, transfer never completed");
    summary();
  end

  initial begin
    logic [15:0] v;
    int cnt;
    repeat (3) @(posedge clk);
    #2; rst_n = 1; started = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 cs_out", cs_out, 4'hF);
    chk("R11 sclk", sclk, 0);
    chk("R11 sdo", sdo, 0);
    peek(3'd1, 0, v); chk("R11 csr", v, 0);

    // R1 setup words and readback; R10 packing of per-select settings
    wr(3'd2, 16'h0240);
    wr(3'd3, 16'h0856);
    wr(3'd4, 16'h0002);
    wr(3'd5, 16'h0000);
    wr(3'd6, 16'h1234);
    peek(3'd2, 0, v); chk("R1 setup1", v, 16'h0240);
    peek(3'd3, 0, v); chk("R1 setup2", v, 16'h0856);
    peek(3'd6, 0, v); chk("R1 setup5", v, 16'h1234);
    peek(3'd7, 0, v); chk("R1 index7", v, 0);
    // R2 cs2 is active high, so its inactive level is 0
    chk("R2 idle levels", cs_out, 4'b1011);

    wr(3'd1, cmd(0, 1, 0, 0, 0));
    @(negedge clk); chk("R2 cs0 asserted", cs_out, 4'b1010);

    // R3 write length 31 clamps to 16; R4 half period of 1 tick at divide-by-2
    wr(3'd0, 16'hA5C3);
    wr(3'd1, cmd(1, 1, 0, 31, 0));
    cnt = 0;
    forever begin
      @(negedge clk);
      if (rdata[14]) cnt++; else break;
    end
    chk("R3 clamped busy cycles", cnt, 32);
    peek(3'd1, 0, v); chk("R3 raw field kept", v[9:5], 31);

    // R3 zero lengths start nothing
    wr(3'd1, cmd(1, 1, 0, 0, 0));
    @(negedge clk); chk("R3 zero-length start", rdata[14], 0);

    // R6 read of 8 bits on cs1 (sample at end, divide by 4), sparse tick
    tick_mode = 1;
    wr(3'd1, cmd(0, 1, 1, 0, 0));
    wr(3'd1, cmd(1, 1, 1, 0, 8));
    // R9 command write while busy is ignored
    wr(3'd1, cmd(1, 1, 3, 4, 4));
    @(negedge clk); chk("R9 cs index kept", rdata[11:10], 1);
    chk("R9 cs1 still asserted", cs_out, 4'b1001);
    wait_idle();
    peek(3'd1, 0, v); chk("R8 ready after read transfer", v[15], 1);
    peek(3'd0, 1, v); chk("R6 upper bits clear", v[15:8], 0);
    peek(3'd1, 0, v); chk("R8 ready cleared by read", v[15], 0);

    // R7 write then read on cs2: rising drive, divide by 8, inverted clock
    tick_mode = 0;
    wr(3'd5, 16'h0001);
    @(negedge clk); chk("R4 inverted idle", sclk, 1);
    wr(3'd0, 16'h9000);
    wr(3'd1, cmd(0, 1, 2, 0, 0));
    wr(3'd1, cmd(1, 1, 2, 4, 5));
    cnt = 0;
    forever begin
      @(negedge clk);
      if (rdata[14]) cnt++; else break;
      if (cnt == 10) begin
        // R10 divider change mid-transfer must not affect the running one
        @(posedge clk); #2; addr = 3'd3; wdata = 16'h0846; wr_en = 1;
        @(posedge clk); #2; wr_en = 0; addr = 3'd1;
        cnt++;
      end
    end
    chk("R10 latched divider length", cnt, 72);
    peek(3'd1, 0, v); chk("R7 read phase completed", v[15], 1);
    peek(3'd0, 1, v);

    // R8 collision: read strobe held on index 0 through the finishing edge
    wr(3'd5, 16'h0000);
    wr(3'd1, cmd(0, 1, 0, 0, 0));
    wr(3'd1, cmd(1, 1, 0, 0, 3));
    @(posedge clk); #2; addr = 3'd0; rd_en = 1;
    wait_idle();
    #1; rd_en = 0; addr = 3'd1;
    @(negedge clk); chk("R8 set wins over read", rdata[15], 1);

    wr(3'd1, cmd(0, 0, 0, 0, 0));
    @(negedge clk); chk("R2 deasserted", cs_out, 4'b1011);
    repeat (4) @(posedge clk);
    summary();
  end
endmodule